// File: doc/BRIEF.md
# Five-Source Interrupt Dispatcher

This block arbitrates the interrupts of a small processor core that has five interrupt sources. It holds the enable register and the flag register. Each cycle it forms the set of requests that are effectively pending: a source counts only if its enable bit is set, its flag bit is set, and its bit in an external hold-off mask is clear. Only the five low bits of each register take part. The upper three bits of each register are stored and read back but never arbitrated.

A non-empty effective set releases the core from halt whether or not the master enable is on. The master enable is switched by set and clear requests. A request is held as a pending change and takes effect at the next instruction boundary after the one on which it was made. At an instruction boundary where the master enable is on and the effective set is not empty, the block dispatches the lowest-numbered pending source. In that same cycle it presents the source's index and its vector address, and it raises a one-hot flag-clear. At the closing edge of that cycle it drops that source's flag bit and the master enable.

Top module: `irq_dispatcher`

## Requirements
- R1: The effective pending output `pend_set` equals bits 4..0 of `ie_q`, AND bits 4..0 of `if_q`, AND the inverse of `dly_mask`. Bit i of each vector belongs to source i.
- R2: When `pend_set` is non-zero, `halted` is 0 after the next clock edge, even when `ime` is 0. `halt_req` sets `halted` only when `pend_set` is zero.
- R3: `dispatch` is 1 exactly in a cycle where `insn_end` is 1, `ime` is 1 and `pend_set` is non-zero. It is combinational in that cycle.
- R4: On dispatch, `vec_idx` is the lowest set bit position of `pend_set`, and `if_clr` is the one-hot mask of that bit. Outside a dispatch, `if_clr` is zero.
- R5: `vec_addr` equals 0x40 + 8 × `vec_idx`, so source 0 gives 0x40 and source 4 gives 0x60.
- R6: After the edge that closes a dispatch cycle, `ime` is 0 and the dispatched flag bit in `if_q` is 0, unless that bit was raised in the same cycle. Any master-enable change that was still pending is discarded.
- R7: A set or clear request for the master enable changes `ime` only at the edge closing the first `insn_end` cycle that comes strictly after the request cycle. When both requests are made together, the clear wins.
- R8: A source whose `dly_mask` bit is 1 neither wakes the core nor is dispatched. It becomes eligible in the same cycle its mask bit returns to 0, with no other change.
- R9: Bits 7..5 of `ie_q` and `if_q` read back exactly as written and have no effect on `pend_set`.
- R10: After reset, `ie_q`, `if_q`, `ime` and `halted` are 0, and `dispatch` is 0.
- R11: A flag write replaces the register. The dispatch clear is applied after the write. `irq_raise` bits are ORed in last, so a raise wins over both the write and the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ie_we | input | 1 | Enable register write strobe |
| ie_wdata | input | 8 | Enable register write data |
| if_we | input | 1 | Flag register write strobe |
| if_wdata | input | 8 | Flag register write data |
| irq_raise | input | 5 | Per-source flag set pulses |
| dly_mask | input | 5 | Per-source hold-off mask for this cycle |
| ime_set_req | input | 1 | Request to turn the master enable on |
| ime_clr_req | input | 1 | Request to turn the master enable off |
| halt_req | input | 1 | Core enters halt |
| insn_end | input | 1 | Instruction boundary strobe |
| ie_q | output | 8 | Enable register contents |
| if_q | output | 8 | Flag register contents |
| ime | output | 1 | Current master enable |
| halted | output | 1 | Core halted state |
| pend_set | output | 5 | Effective pending set |
| dispatch | output | 1 | Dispatch pulse |
| vec_idx | output | 3 | Selected source index |
| vec_addr | output | 8 | Selected vector address |
| if_clr | output | 5 | One-hot flag clear of the dispatched source |

## Verification
The arbitration is driven with several flag patterns that hold more than one pending source: bits 2, 3 and 4 together, bits 0 and 1 together, and each one alone. These show that the scan order is from the low end and that the vector arithmetic is right at the first and last source. The same patterns are repeated with the hold-off mask covering the winner. This separates masking from enabling and shows that the next-lowest source wins. The master enable is requested both away from a boundary and on a boundary, which tells a one-boundary lag from an immediate or a two-boundary change. Halt wake-up is run with the master enable off and with the waking source first held off. This shows that wake-up depends only on the effective set.

// File: rtl/irq_pkg.sv
// Package irq_pkg
// Holds the shared defaults and types of the interrupt dispatcher.
// Assumes every user elaborates with the same source count.
package irq_pkg;
    localparam int NUM_SRC_D  = 5;
    localparam int REG_W_D    = 8;
    localparam int ADDR_W_D   = 8;
    localparam int VEC_BASE_D = 'h40;
    localparam int VEC_STEP_D = 8;

    // Pending change of the master enable.
    typedef struct packed {
        logic vld;
        logic val;
    } ime_tog_t;
endpackage

// File: rtl/irq_regs.sv
// Module irq_regs
// Stores the interrupt enable and interrupt flag registers.
// Update order for the flags: a write replaces the register, then the
// dispatch clear is applied, then raise pulses are ORed in.
// Assumes REG_W >= NSRC. Bits above NSRC are only stored.
module irq_regs #(
    parameter int NSRC  = irq_pkg::NUM_SRC_D,
    parameter int REG_W = irq_pkg::REG_W_D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ie_we,
    input  logic [REG_W-1:0] ie_wdata,
    input  logic             if_we,
    input  logic [REG_W-1:0] if_wdata,
    input  logic [NSRC-1:0]  raise,
    input  logic [NSRC-1:0]  clr,
    output logic [REG_W-1:0] ie_q,
    output logic [REG_W-1:0] if_q
);
    localparam int PAD_W = REG_W - NSRC;

    logic [REG_W-1:0] raise_w;
    logic [REG_W-1:0] clr_w;
    logic [REG_W-1:0] if_base;
    logic [REG_W-1:0] if_next;

    // Widen the per-source vectors to register width.
    always_comb begin
        raise_w = {{PAD_W{1'b0}}, raise};
        clr_w   = {{PAD_W{1'b0}}, clr};
        if_base = if_we ? if_wdata : if_q;
        if_next = (if_base & ~clr_w) | raise_w;
    end

    // Enable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     ie_q <= '0;
        else if (ie_we) ie_q <= ie_wdata;
    end

    // Flag register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) if_q <= '0;
        else        if_q <= if_next;
    end
endmodule

// File: rtl/irq_prio.sv
// Module irq_prio
// Fixed-priority picker. The lowest set request bit wins. It also gives
// the binary index of the winner and its vector address.
// Assumes IDX_W bits can hold NSRC-1. The address wraps modulo 2**ADDR_W.
module irq_prio #(
    parameter int NSRC     = irq_pkg::NUM_SRC_D,
    parameter int IDX_W    = $clog2(NSRC),
    parameter int ADDR_W   = irq_pkg::ADDR_W_D,
    parameter int VEC_BASE = irq_pkg::VEC_BASE_D,
    parameter int VEC_STEP = irq_pkg::VEC_STEP_D
) (
    input  logic [NSRC-1:0]   req,
    output logic [NSRC-1:0]   grant,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    logic [NSRC-1:0] seen_below;

    // Chain that marks whether any lower bit is already requesting.
    for (genvar g = 0; g < NSRC; g++) begin : g_chain
        if (g == 0) begin : g_first
            assign seen_below[g] = 1'b0;
        end else begin : g_rest
            assign seen_below[g] = seen_below[g-1] | req[g-1];
        end
        assign grant[g] = req[g] & ~seen_below[g];
    end

    // Turn the one-hot grant into a binary index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) idx = idx | IDX_W'(i);
        end
    end

    // Vector address of the selected source.
    always_comb begin
        addr = ADDR_W'(VEC_BASE) + ADDR_W'(idx) * ADDR_W'(VEC_STEP);
    end
endmodule

// File: rtl/irq_core_ctrl.sv
// Module irq_core_ctrl
// Holds the master enable with its pending change, and the halt state.
// A change request is stored and applied at the first instruction
// boundary after the request cycle. A dispatch clears the enable and
// drops any stored change. Halt is released by any effective request.
module irq_core_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic insn_end,
    input  logic dispatch,
    input  logic halt_req,
    input  logic any_pend,
    output logic ime,
    output logic halted
);
    import irq_pkg::*;

    ime_tog_t tog_q;
    logic     new_req;

    // Any new enable change this cycle.
    always_comb new_req = set_req | clr_req;

    // Master enable and its stored change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ime   <= 1'b0;
            tog_q <= '0;
        end else if (dispatch) begin
            ime   <= 1'b0;
            tog_q <= '0;
        end else begin
            if (insn_end && tog_q.vld) ime <= tog_q.val;
            if (new_req) begin
                tog_q.vld <= 1'b1;
                tog_q.val <= ~clr_req;
            end else if (insn_end) begin
                tog_q.vld <= 1'b0;
            end
        end
    end

    // Halt state, released whenever something is effectively pending.
    always_ff @(posedge clk) begin
        if (!rst_n)        halted <= 1'b0;
        else if (any_pend) halted <= 1'b0;
        else if (halt_req) halted <= 1'b1;
    end
endmodule

// File: rtl/irq_dispatcher.sv
// Module irq_dispatcher
// Top of the interrupt dispatcher. Forms the effective pending set,
// selects the winner and issues a dispatch at an instruction boundary.
// Assumes dly_mask is valid for the current cycle only.
module irq_dispatcher #(
    parameter int NSRC     = irq_pkg::NUM_SRC_D,
    parameter int REG_W    = irq_pkg::REG_W_D,
    parameter int ADDR_W   = irq_pkg::ADDR_W_D,
    parameter int VEC_BASE = irq_pkg::VEC_BASE_D,
    parameter int VEC_STEP = irq_pkg::VEC_STEP_D,
    localparam int IDX_W   = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ie_we,
    input  logic [REG_W-1:0]  ie_wdata,
    input  logic              if_we,
    input  logic [REG_W-1:0]  if_wdata,
    input  logic [NSRC-1:0]   irq_raise,
    input  logic [NSRC-1:0]   dly_mask,
    input  logic              ime_set_req,
    input  logic              ime_clr_req,
    input  logic              halt_req,
    input  logic              insn_end,
    output logic [REG_W-1:0]  ie_q,
    output logic [REG_W-1:0]  if_q,
    output logic              ime,
    output logic              halted,
    output logic [NSRC-1:0]   pend_set,
    output logic              dispatch,
    output logic [IDX_W-1:0]  vec_idx,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [NSRC-1:0]   if_clr
);
    logic [NSRC-1:0] grant;
    logic            any_pend;

    irq_regs #(.NSRC(NSRC), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ie_we    (ie_we),
        .ie_wdata (ie_wdata),
        .if_we    (if_we),
        .if_wdata (if_wdata),
        .raise    (irq_raise),
        .clr      (if_clr),
        .ie_q     (ie_q),
        .if_q     (if_q)
    );

    // Effective pending set: only the low source bits take part.
    always_comb begin
        pend_set = ie_q[NSRC-1:0] & if_q[NSRC-1:0] & ~dly_mask;
        any_pend = |pend_set;
    end

    irq_prio #(
        .NSRC(NSRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
        .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
    ) u_prio (
        .req   (pend_set),
        .grant (grant),
        .idx   (vec_idx),
        .addr  (vec_addr)
    );

    // Dispatch at a boundary with the enable on and work pending.
    always_comb begin
        dispatch = insn_end & ime & any_pend;
        if_clr   = dispatch ? grant : '0;
    end

    irq_core_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (ime_set_req),
        .clr_req  (ime_clr_req),
        .insn_end (insn_end),
        .dispatch (dispatch),
        .halt_req (halt_req),
        .any_pend (any_pend),
        .ime      (ime),
        .halted   (halted)
    );
endmodule

// File: rtl/irq_dispatcher_chk.sv
// Module irq_dispatcher_chk
// Property checker bound to irq_dispatcher. It observes ports only.
module irq_dispatcher_chk #(
    parameter int NSRC  = 5,
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             if_we,
    input logic [NSRC-1:0]  irq_raise,
    input logic [NSRC-1:0]  dly_mask,
    input logic             insn_end,
    input logic [REG_W-1:0] if_q,
    input logic             ime,
    input logic             halted,
    input logic [NSRC-1:0]  pend_set,
    input logic             dispatch,
    input logic [NSRC-1:0]  if_clr
);
    // R2: pending work releases halt at the next edge.
    a_r2_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && (pend_set != '0)) |=> !halted);

    // R3: dispatch needs a boundary, the enable and pending work.
    a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> (insn_end && ime && (pend_set != '0)));

    // R4: exactly one source is cleared per dispatch, none otherwise.
    a_r4_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> ($countones(if_clr) == 1));
    a_r4_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !dispatch |-> (if_clr == '0));

    // R6: the enable drops after a dispatch.
    a_r6_ime_off: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |=> !ime);

    // R6: the dispatched flag drops unless written or raised again.
    a_r6_flag_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch && !if_we && ((irq_raise & if_clr) == '0))
            |=> ((if_q[NSRC-1:0] & $past(if_clr)) == '0));

    // R7: the enable changes only across a boundary cycle.
    a_r7_lag: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_end |=> $stable(ime));

    // R8: a held-off source is never serviced.
    a_r8_held: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch |-> ((if_clr & dly_mask) == '0));
endmodule

bind irq_dispatcher irq_dispatcher_chk #(.NSRC(NSRC), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .if_we     (if_we),
    .irq_raise (irq_raise),
    .dly_mask  (dly_mask),
    .insn_end  (insn_end),
    .if_q      (if_q),
    .ime       (ime),
    .halted    (halted),
    .pend_set  (pend_set),
    .dispatch  (dispatch),
    .if_clr    (if_clr)
);

// File: tb/irq_dispatcher_bench.sv
// Directed bench for irq_dispatcher. Inputs change on the falling edge.
// Combinational outputs are read 1 ns after a change. Registered outputs
// are read at the falling edge after the rising edge that loads them.
module irq_dispatcher_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ie_we, if_we;
    logic [7:0] ie_wdata, if_wdata;
    logic [4:0] irq_raise, dly_mask;
    logic       ime_set_req, ime_clr_req, halt_req, insn_end;
    logic [7:0] ie_q, if_q;
    logic       ime, halted, dispatch;
    logic [4:0] pend_set, if_clr;
    logic [2:0] vec_idx;
    logic [7:0] vec_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    irq_dispatcher u_irq_dispatcher (
        .clk(clk), .rst_n(rst_n),
        .ie_we(ie_we), .ie_wdata(ie_wdata),
        .if_we(if_we), .if_wdata(if_wdata),
        .irq_raise(irq_raise), .dly_mask(dly_mask),
        .ime_set_req(ime_set_req), .ime_clr_req(ime_clr_req),
        .halt_req(halt_req), .insn_end(insn_end),
        .ie_q(ie_q), .if_q(if_q), .ime(ime), .halted(halted),
        .pend_set(pend_set), .dispatch(dispatch), .vec_idx(vec_idx),
        .vec_addr(vec_addr), .if_clr(if_clr)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ie(input logic [7:0] v);
        ie_we = 1'b1; ie_wdata = v; tick(); ie_we = 1'b0;
    endtask

    task automatic wr_if(input logic [7:0] v);
        if_we = 1'b1; if_wdata = v; tick(); if_we = 1'b0;
    endtask

    // Request the enable, then pass one boundary so it takes effect.
    task automatic ime_on();
        ime_set_req = 1'b1; tick(); ime_set_req = 1'b0;
        insn_end = 1'b1; tick(); insn_end = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "ie_q", ie_q, 0);
        chk("R10", "if_q", if_q, 0);
        chk("R10", "ime", ime, 0);
        chk("R10", "halted", halted, 0);
        chk("R10", "dispatch", dispatch, 0);
    endtask

    task automatic t_pending();
        wr_ie(8'hFF); wr_if(8'hE5);
        chk("R1", "pend all", pend_set, 5'h05);
        chk("R9", "ie readback", ie_q, 8'hFF);
        chk("R9", "if readback", if_q, 8'hE5);
        dly_mask = 5'h01; #1;
        chk("R1", "pend masked", pend_set, 5'h04);
        dly_mask = 5'h00;
        wr_ie(8'hE0); wr_if(8'hFF);
        chk("R9", "upper bits idle", pend_set, 5'h00);
        chk("R9", "if upper readback", if_q, 8'hFF);
        wr_if(8'h00);
    endtask

    task automatic t_ime_lag();
        ime_set_req = 1'b1; tick(); ime_set_req = 1'b0;
        chk("R7", "no change before boundary", ime, 0);
        tick();
        chk("R7", "still held", ime, 0);
        insn_end = 1'b1; tick(); insn_end = 1'b0;
        chk("R7", "applied at boundary", ime, 1);
        ime_clr_req = 1'b1; insn_end = 1'b1; tick();
        ime_clr_req = 1'b0; insn_end = 1'b0;
        chk("R7", "request on boundary waits", ime, 1);
        insn_end = 1'b1; tick(); insn_end = 1'b0;
        chk("R7", "clear applied", ime, 0);
        ime_set_req = 1'b1; ime_clr_req = 1'b1; tick();
        ime_set_req = 1'b0; ime_clr_req = 1'b0;
        insn_end = 1'b1; tick(); insn_end = 1'b0;
        chk("R7", "clear wins", ime, 0);
    endtask

    task automatic t_priority();
        wr_ie(8'h1F); wr_if(8'h1C);
        insn_end = 1'b1; #1;
        chk("R3", "no dispatch with ime off", dispatch, 0);
        tick(); insn_end = 1'b0;
        ime_on();
        insn_end = 1'b1; #1;
        chk("R3", "dispatch", dispatch, 1);
        chk("R4", "idx lowest", vec_idx, 2);
        chk("R4", "clear mask", if_clr, 5'h04);
        chk("R5", "vector", vec_addr, 8'h50);
        tick(); insn_end = 1'b0;
        chk("R6", "flag dropped", if_q, 8'h18);
        chk("R6", "ime dropped", ime, 0);
        ime_on();
        insn_end = 1'b1; #1;
        chk("R4", "next idx", vec_idx, 3);
        tick(); insn_end = 1'b0;
        ime_on();
        insn_end = 1'b1; #1;
        chk("R5", "last vector", vec_addr, 8'h60);
        tick(); insn_end = 1'b0;
        chk("R6", "all flags gone", if_q, 8'h00);
        #1 chk("R4", "no clear idle", if_clr, 5'h00);
    endtask

    task automatic t_wake();
        halt_req = 1'b1; tick(); halt_req = 1'b0;
        chk("R2", "halt entered", halted, 1);
        dly_mask = 5'h02; irq_raise = 5'h02; tick(); irq_raise = 5'h00;
        tick();
        chk("R8", "held source no wake", halted, 1);
        chk("R8", "flag stored", if_q, 8'h02);
        dly_mask = 5'h00; #1;
        chk("R8", "eligible at once", pend_set, 5'h02);
        tick();
        chk("R2", "woken with ime off", halted, 0);
        halt_req = 1'b1; tick(); halt_req = 1'b0;
        chk("R2", "no halt while pending", halted, 0);
        wr_if(8'h00);
    endtask

    task automatic t_held_dispatch();
        wr_if(8'h03);
        ime_on();
        dly_mask = 5'h01; insn_end = 1'b1; #1;
        chk("R8", "held winner skipped", vec_idx, 1);
        chk("R8", "clear skipped", if_clr, 5'h02);
        tick(); insn_end = 1'b0; dly_mask = 5'h00;
        ime_on();
        insn_end = 1'b1; #1;
        chk("R5", "first vector", vec_addr, 8'h40);
        tick(); insn_end = 1'b0;
        chk("R6", "flags cleared", if_q, 8'h00);
    endtask

    task automatic t_if_order();
        wr_if(8'h01);
        ime_on();
        ime_set_req = 1'b1; insn_end = 1'b1; irq_raise = 5'h01; #1;
        chk("R3", "dispatch bit0", dispatch, 1);
        tick(); insn_end = 1'b0; irq_raise = 5'h00; ime_set_req = 1'b0;
        chk("R11", "raise beats clear", if_q, 8'h01);
        insn_end = 1'b1; tick(); insn_end = 1'b0;
        chk("R6", "stored change dropped", ime, 0);
        if_we = 1'b1; if_wdata = 8'h00; irq_raise = 5'h04; tick();
        if_we = 1'b0; irq_raise = 5'h00;
        chk("R11", "raise beats write", if_q, 8'h04);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ie_we = 1'b0; if_we = 1'b0; ie_wdata = '0; if_wdata = '0;
        irq_raise = '0; dly_mask = '0; ime_set_req = 1'b0; ime_clr_req = 1'b0;
        halt_req = 1'b0; insn_end = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        t_reset();
        t_pending();
        t_ime_lag();
        t_priority();
        t_wake();
        t_held_dispatch();
        t_if_order();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule